// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

Two 8-bit down-counting interval timers sit behind one 32-bit control word. Each timer has its own reload divider, a choice of four tick sources, a hold-and-load or count mode, and an interrupt flag that software acknowledges through a write-only bit in the same word. The tick sources are single-cycle enable strobes in the system clock domain: a fast strobe, a slow strobe, the output of a shared programmable prescaler, and the terminal-count pulse of the other timer. Chaining the two timers gives a period equal to the product of both dividers.

Software writes the control word and the prescaler reload value. It reads back the control word, the reload value, and a snapshot word that carries both live counts together with the prescaler's current phase. Because all three values are captured on the same clock edge, software can compute a timestamp finer than one timer tick. Each timer drives one level interrupt, gated by a per-timer enable input.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset the control word, prescaler reload and prescaler phase are zero, both counts read 0, and both interrupts are low.
- R2: While a timer's mode bit is 0 (hold-and-load), its count takes the divider field value on every cycle. Switching to mode 0 in the middle of a count restores the divider value.
- R3: While the mode bit is 1 (count), every strobe from the selected source lowers the count by one. The count therefore reads the divider minus the ticks elapsed since the last reload.
- R4: A tick that arrives while the count is 1 reloads the divider and sets the timer's interrupt flag, so the period is exactly the divider value in ticks. A divider of 0 gives a period of 256 ticks.
- R5: Source field encoding: 0 selects the fast strobe, 1 the slow strobe, 2 the prescaler output and 3 the other timer's terminal pulse. Strobes from unselected sources leave the count unchanged.
- R6: A timer whose source field is 3 advances once for each reload of the other timer. Timer 0 with divider A, chained into timer 1 with divider B, raises timer 1's interrupt after A*B fast ticks.
- R7: A control write with a timer's ack bit at 1 clears that timer's pending flag. The divider, mode and source written in the same word take effect, and the ack bit reads back as 0.
- R8: The prescaler reload value P (0 meaning 65536) gives a phase that starts at P-1 when P is written. The phase drops by one per base strobe; a base strobe at phase 0 emits a prescaler pulse and returns the phase to P-1.
- R9: Register map. Address 0 is the control word: timer i uses bits [16i+15:16i], with the divider at [7:0], ack at [8], mode at [9], source at [11:10] and [15:12] reserved as zero. Address 1 holds the reload value in [15:0]. Address 2 is read-only and returns {phase[15:0], count1, count0}; writes to it are ignored. Address 3 reads 0. Read data and rd_valid appear on the clock edge after rd_en.
- R10: irq[i] equals timer i's pending flag ANDed with irq_en[i]. A masked flag stays pending and shows as soon as the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Registered read data |
| fast_stb | input | 1 | Fast tick strobe (source 0) |
| slow_stb | input | 1 | Slow tick strobe (source 1) |
| base_stb | input | 1 | Prescaler input strobe |
| irq_en | input | 2 | Per-timer interrupt enable |
| irq | output | 2 | Level interrupts, bit i for timer i |

## Verification
A control write takes effect on its own edge, and a held count follows the new divider on the edge after that. A direct strobe changes the count on the edge that samples it. A prescaler tick or a chained tick arrives one edge later, because the prescaler output and the terminal pulse are both registered. The interrupt flag rises on the same edge as the reload, and irq follows it combinationally. A read returns its value one edge after rd_en, and that value shows the state before the edge. Each read is therefore issued two idle cycles after the last stimulus, and interrupt levels are sampled three falling edges later. The driver pushes each expected read word into a queue, and a monitor pops and compares it on the falling edge where rd_valid is high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W   = 8;
    localparam int PHASE_W = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int N_TMR   = 2;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_RUN  = 1'b1
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_SLOW  = 2'd1,
        SRC_PRESC = 2'd2,
        SRC_CHAIN = 2'd3
    } tmr_src_e;

    // One 16-bit field per timer inside the control word.
    typedef struct packed {
        logic [3:0]       rsvd;
        tmr_src_e         src;
        tmr_mode_e        mode;
        logic             ack;
        logic [CNT_W-1:0] div;
    } tmr_field_t;

    typedef struct packed {
        tmr_field_t t1;
        tmr_field_t t0;
    } tmr_ctrl_t;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SNAP  = 2'd2;

    // Stored form of a field: the ack bit is an action, never kept.
    function automatic tmr_field_t keep_cfg(tmr_field_t f);
        tmr_field_t r;
        r      = f;
        r.ack  = 1'b0;
        r.rsvd = '0;
        return r;
    endfunction
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
    import tmr_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         base_stb,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] reload,
    output logic [W-1:0] phase,
    output logic         pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            phase  <= '0;
            pulse  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (load) begin
                reload <= load_val;
                phase  <= load_val - 1'b1;
            end else if (base_stb) begin
                if (phase == '0) begin
                    phase <= reload - 1'b1;
                    pulse <= 1'b1;
                end else begin
                    phase <= phase - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_field_t   cfg,
    input  logic         fast_stb,
    input  logic         slow_stb,
    input  logic         presc_stb,
    input  logic         chain_stb,
    input  logic         ack_clr,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         wrap,
    output logic         tick
);
    logic term;

    always_comb begin
        unique case (cfg.src)
            SRC_FAST:  tick = fast_stb;
            SRC_SLOW:  tick = slow_stb;
            SRC_PRESC: tick = presc_stb;
            default:   tick = chain_stb;
        endcase
    end

    assign term = (cfg.mode == MODE_RUN) && tick && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
            wrap <= 1'b0;
        end else begin
            wrap <= term;
            if (cfg.mode == MODE_LOAD) begin
                cnt <= cfg.div;
            end else if (tick) begin
                cnt <= term ? cfg.div : cnt - 1'b1;
            end
            if (term) begin
                flag <= 1'b1;
            end else if (ack_clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fast_stb,
    input  logic              slow_stb,
    input  logic              base_stb,
    input  logic [N_TMR-1:0]  irq_en,
    output logic [N_TMR-1:0]  irq
);
    tmr_ctrl_t                     ctrl_q;
    tmr_ctrl_t                     wr_word;
    tmr_field_t [N_TMR-1:0]        fld;
    tmr_field_t [N_TMR-1:0]        wr_fld;
    logic [N_TMR-1:0][CNT_W-1:0]   cnt_w;
    logic [N_TMR-1:0]              flag_w;
    logic [N_TMR-1:0]              wrap_w;
    logic [N_TMR-1:0]              tick_w;
    logic [N_TMR-1:0]              ack_w;
    logic                          ctrl_wr;
    logic [PHASE_W-1:0]            presc_reload;
    logic [PHASE_W-1:0]            presc_phase;
    logic                          presc_pulse;

    assign wr_word   = tmr_ctrl_t'(wr_data);
    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign fld[0]    = ctrl_q.t0;
    assign fld[1]    = ctrl_q.t1;
    assign wr_fld[0] = wr_word.t0;
    assign wr_fld[1] = wr_word.t1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.t0 <= keep_cfg(wr_word.t0);
            ctrl_q.t1 <= keep_cfg(wr_word.t1);
        end
    end

    tmr_presc #(.W(PHASE_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .base_stb (base_stb),
        .load     (wr_en && (wr_addr == ADDR_PRESC)),
        .load_val (wr_data[PHASE_W-1:0]),
        .reload   (presc_reload),
        .phase    (presc_phase),
        .pulse    (presc_pulse)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign ack_w[i] = ctrl_wr && wr_fld[i].ack;

        tmr_unit #(.W(CNT_W)) u_unit (
            .clk       (clk),
            .rst       (rst),
            .cfg       (fld[i]),
            .fast_stb  (fast_stb),
            .slow_stb  (slow_stb),
            .presc_stb (presc_pulse),
            .chain_stb (wrap_w[N_TMR-1-i]),
            .ack_clr   (ack_w[i]),
            .cnt       (cnt_w[i]),
            .flag      (flag_w[i]),
            .wrap      (wrap_w[i]),
            .tick      (tick_w[i])
        );
    end

    assign irq = flag_w & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (rd_addr)
                    ADDR_CTRL:  rd_data <= ctrl_q;
                    ADDR_PRESC: rd_data <= DATA_W'(presc_reload);
                    ADDR_SNAP:  rd_data <= {presc_phase, cnt_w[1], cnt_w[0]};
                    default:    rd_data <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        base_stb,
    input  logic                        presc_pulse,
    input  tmr_ctrl_t                   ctrl_q,
    input  logic [N_TMR-1:0][CNT_W-1:0] cnt_w,
    input  logic [N_TMR-1:0]            flag_w,
    input  logic [N_TMR-1:0]            wrap_w,
    input  logic [N_TMR-1:0]            tick_w
);
    // R2: a held timer shows its divider one edge later
    a_r2_load_tracks_div: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.t0.mode == MODE_LOAD) |=> (cnt_w[0] == $past(ctrl_q.t0.div)));

    // R3: a counting timer without a tick keeps its count
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q.t1.mode == MODE_RUN) && !tick_w[1]) |=> $stable(cnt_w[1]));

    // R4: every terminal pulse comes with a pending flag
    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        wrap_w[0] |-> flag_w[0]);

    // R7: an ack with no coincident terminal tick leaves the flag clear
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == ADDR_CTRL) && wr_data[8] && !(tick_w[0] && cnt_w[0] == 8'd1))
        |=> !flag_w[0]);

    // R8: a prescaler pulse only follows a base strobe
    a_r8_pulse_after_base: assert property (@(posedge clk) disable iff (rst)
        presc_pulse |-> $past(base_stb));
endmodule

bind dual_interval_timer tmr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .base_stb    (base_stb),
    .presc_pulse (presc_pulse),
    .ctrl_q      (ctrl_q),
    .cnt_w       (cnt_w),
    .flag_w      (flag_w),
    .wrap_w      (wrap_w),
    .tick_w      (tick_w)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        fast_stb = 1'b0;
    logic        slow_stb = 1'b0;
    logic        base_stb = 1'b0;
    logic [1:0]  irq_en = 2'b11;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #5 clk = ~clk;

    dual_interval_timer dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .fast_stb (fast_stb),
        .slow_stb (slow_stb),
        .base_stb (base_stb),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    // Monitor: compare each returned read with the next expected item
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected read: actual %h expected none", rd_data);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
        idle(2);
        sb_q.push_back('{exp, tag});
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // which: 0 fast, 1 slow, 2 base
    task automatic pulse(int which, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            case (which)
                0: fast_stb = 1'b1;
                1: slow_stb = 1'b1;
                default: base_stb = 1'b1;
            endcase
            @(negedge clk);
            fast_stb = 1'b0; slow_stb = 1'b0; base_stb = 1'b0;
        end
    endtask

    task automatic chk_irq(logic [1:0] exp, string tag);
        idle(3);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 32'h0, "R1 control after reset");
        rd(2'd1, 32'h0, "R1 reload after reset");
        rd(2'd2, 32'h0, "R1 snapshot after reset");
        chk_irq(2'b00, "R1 irq after reset");

        // R2 hold-and-load, R9 readback
        wr(2'd0, 32'h0000_0005);
        rd(2'd0, 32'h0000_0005, "R9 control readback");
        rd(2'd2, 32'h0000_0005, "R2 held count equals divider");

        // R3 counting, R5 unselected source ignored, R4 reload
        wr(2'd0, 32'h0000_0205);
        pulse(0, 2);
        rd(2'd2, 32'h0000_0003, "R3 count after two ticks");
        pulse(1, 3);
        rd(2'd2, 32'h0000_0003, "R5 slow strobes ignored");
        pulse(0, 2);
        chk_irq(2'b00, "R4 no irq before terminal tick");
        pulse(0, 1);
        chk_irq(2'b01, "R4 irq at divider ticks");
        rd(2'd2, 32'h0000_0005, "R4 reload after terminal tick");

        // R7 ack with new fields
        wr(2'd0, 32'h0000_0307);
        chk_irq(2'b00, "R7 ack clears flag");
        rd(2'd0, 32'h0000_0207, "R7 fields applied, ack reads 0");
        rd(2'd2, 32'h0000_0005, "R7 count untouched by ack");

        // R10 mask
        irq_en = 2'b10;
        pulse(0, 5);
        chk_irq(2'b00, "R10 masked irq stays low");
        irq_en = 2'b11;
        chk_irq(2'b01, "R10 pending flag shows when enabled");
        wr(2'd0, 32'h0000_0307);
        chk_irq(2'b00, "R7 second ack");

        // R4 divider 0 means 256
        wr(2'd0, 32'h0000_0000);
        wr(2'd0, 32'h0000_0200);
        pulse(0, 255);
        chk_irq(2'b00, "R4 no irq after 255 ticks with divider 0");
        rd(2'd2, 32'h0000_0001, "R4 count 1 after 255 ticks");
        pulse(0, 1);
        chk_irq(2'b01, "R4 irq after 256 ticks with divider 0");
        rd(2'd2, 32'h0000_0000, "R4 reload of divider 0");

        // R6 chaining: timer0 div 3 fast, timer1 div 2 from timer0
        wr(2'd0, 32'h0C02_0103);
        wr(2'd0, 32'h0E02_0203);
        pulse(0, 3);
        chk_irq(2'b01, "R6 timer0 wraps after 3");
        rd(2'd2, 32'h0000_0103, "R6 timer1 advanced once");
        pulse(0, 2);
        chk_irq(2'b01, "R6 timer1 not yet at 5 ticks");
        pulse(0, 1);
        chk_irq(2'b11, "R6 timer1 irq after 6 ticks");
        rd(2'd2, 32'h0000_0203, "R6 timer1 reloaded");

        // R8 prescaler source
        wr(2'd0, 32'h0100_0902);
        chk_irq(2'b00, "R7 ack both timers");
        wr(2'd1, 32'h0000_0004);
        rd(2'd1, 32'h0000_0004, "R8 reload readback");
        rd(2'd2, 32'h0003_0002, "R8 phase starts at P-1");
        wr(2'd0, 32'h0000_0A02);
        pulse(2, 1);
        rd(2'd2, 32'h0002_0002, "R8 phase after one base strobe");
        pulse(2, 3);
        rd(2'd2, 32'h0003_0001, "R8 phase wraps and timer ticks");
        chk_irq(2'b00, "R8 no irq after one prescaler period");
        pulse(2, 4);
        chk_irq(2'b01, "R8 irq after two prescaler periods");
        rd(2'd2, 32'h0003_0002, "R8 timer reloaded from prescaler");

        // R2 stop mid count, R9 snapshot not writable
        wr(2'd0, 32'h0000_0109);
        wr(2'd0, 32'h0000_0209);
        pulse(0, 3);
        rd(2'd2, 32'h0003_0006, "R3 count after three ticks");
        wr(2'd0, 32'h0000_0009);
        rd(2'd2, 32'h0003_0009, "R2 load restores divider");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h0003_0009, "R9 snapshot write ignored");
        rd(2'd0, 32'h0000_0009, "R9 control after ignored write");
        rd(2'd3, 32'h0000_0000, "R9 unused address reads 0");

        idle(4);
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9 missing reads: actual %0d pending expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule